// File: doc/BRIEF.md
# Row-Column Static RAM Array

This block is a static RAM whose storage cells form a square array of rows and columns rather than a flat list of words. The low part of the address is decoded into a one-hot row select that picks one full row of cells. The upper part of the address is decoded into a one-hot column select. On a read, the column select steers a set of column multiplexers across the selected row. On a write, the same select acts as a column demultiplexer, so that only the addressed cells of the selected row take the new data.

Two shapes are built from the same source, and a parameter chooses between them. With one data bit the array holds 65536 words of one bit, and a single 256-to-1 column multiplexer serves the whole row. With four data bits the array holds 16384 words of four bits: each row is split into four groups of 64 cells, and each group has its own 64-to-1 multiplexer and 1-to-64 demultiplexer. A chip-select input lets several arrays share one address and data bus. A single read/write line selects the operation. Writes are taken on the rising clock edge. Reads are combinational.

Top module: `sram_rc`

## Requirements
- R1: The low 8 address bits select one of 256 rows and the bits above them select the column; every address reaches storage of its own, so writing one address never changes the word read back at any other address.
- R2: With the default DATA_W of 1, the address is 16 bits wide, the column field is addr[15:8], and each word is one bit.
- R3: With DATA_W of 4, the address is 14 bits wide and the column field is addr[13:8]. Each row is cut into four groups of 64 cells, and data bit g is stored in group g at the addressed column.
- R4: When cs is 1 and rw is 0 (write), din is stored at the addressed word on the rising clock edge. A later read of that address returns it, and no other word changes.
- R5: When cs is 1 and rw is 1 (read), dout shows the addressed word in the same cycle, with no clock edge needed. Repeated reads with no write in between return the same value.
- R6: dout is all zeros whenever cs is 0 or rw is 0, including before any access.
- R7: A write cycle with cs at 0 changes no stored word.
- R8: For every address, the row decoder and the column decoder each give exactly one active line. Both decoders are built from predecoders of at most 3 inputs, joined by gates with a fan-in of no more than 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; a write is taken on the rising edge |
| addr | input | ROW_BITS + column bits (16 or 14) | Word address: row field in the low bits, column field above it |
| din | input | DATA_W | Write data |
| rw | input | 1 | 1 = read, 0 = write |
| cs | input | 1 | Chip select; nothing happens while it is 0 |
| dout | output | DATA_W | Read data, all zeros when not reading |

## Verification
A wrong row or column decode shows at the ports only through aliasing: a word written at one address reappears at another address, or a neighbouring cell is overwritten. Such a fault shows on the first read of an affected address after the write, and it can be any number of cycles later. For that reason the bench writes every row at both edge columns and every column of the edge rows before reading any of them back. A bad idle gate or a broken chip-select qualifier shows at once: in the same cycle as a non-zero dout, or on the first read after a write with cs low.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;

   localparam int unsigned PRE_W_DEF  = 3;
   localparam int unsigned FANIN_MAX  = 8;
   localparam logic        RW_READ    = 1'b1;
   localparam logic        RW_WRITE   = 1'b0;

   function automatic int unsigned row_cells(input int unsigned rb);
      return 32'd1 << rb;
   endfunction

   function automatic int unsigned group_cells(input int unsigned rb, input int unsigned dw);
      return (32'd1 << rb) / dw;
   endfunction

   function automatic int unsigned col_bits(input int unsigned rb, input int unsigned dw);
      return $clog2(group_cells(rb, dw));
   endfunction

   function automatic int unsigned addr_bits(input int unsigned rb, input int unsigned dw);
      return rb + col_bits(rb, dw);
   endfunction

   function automatic int unsigned chunk_count(input int unsigned w, input int unsigned pw);
      return (w + pw - 1) / pw;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sram_rc_predec.sv
module sram_rc_predec #(
   parameter int unsigned W = 3
) (
   input  logic [W-1:0]          sel,
   output logic [(1 << W)-1:0]   hot
);
   localparam int unsigned LINES = 1 << W;

   if (W < 1 || W > 3) begin : g_bad_width
      $error("sram_rc_predec: W must be 1..3 so each line gate has fan-in of at most 3");
   end

   for (genvar k = 0; k < LINES; k++) begin : g_line
      assign hot[k] = (sel == W'(k));
   end
endmodule

// File: rtl/sram_rc_dec.sv
module sram_rc_dec
   import sram_rc_pkg::*;
#(
   parameter int unsigned IN_W  = 8,
   parameter int unsigned PRE_W = PRE_W_DEF
) (
   input  logic [IN_W-1:0]          code,
   output logic [(1 << IN_W)-1:0]   hot
);
   localparam int unsigned OUT_N = 1 << IN_W;
   localparam int unsigned NCH   = chunk_count(IN_W, PRE_W);

   if (PRE_W < 1 || PRE_W > 3) begin : g_bad_pre
      $error("sram_rc_dec: PRE_W must be 1..3");
   end
   if (NCH > FANIN_MAX) begin : g_bad_fanin
      $error("sram_rc_dec: final gate fan-in exceeds limit");
   end

   if (IN_W <= PRE_W) begin : g_flat
      sram_rc_predec #(.W(IN_W)) u_pre (
         .sel (code),
         .hot (hot)
      );
   end else begin : g_tree
      for (genvar c = 0; c < NCH; c++) begin : g_chunk
         localparam int unsigned LO = c * PRE_W;
         localparam int unsigned CW = ((IN_W - LO) < PRE_W) ? (IN_W - LO) : PRE_W;
         logic [(1 << CW)-1:0] part;
         sram_rc_predec #(.W(CW)) u_pre (
            .sel (code[LO +: CW]),
            .hot (part)
         );
      end

      for (genvar i = 0; i < OUT_N; i++) begin : g_out
         logic [NCH-1:0] term;
         for (genvar c = 0; c < NCH; c++) begin : g_term
            localparam int unsigned LO  = c * PRE_W;
            localparam int unsigned CW  = ((IN_W - LO) < PRE_W) ? (IN_W - LO) : PRE_W;
            localparam int unsigned IDX = (i >> LO) & ((1 << CW) - 1);
            assign term[c] = g_chunk[c].part[IDX];
         end
         assign hot[i] = &term;
      end
   end
endmodule

// File: rtl/sram_rc_colsel.sv
module sram_rc_colsel #(
   parameter int unsigned DATA_W      = 1,
   parameter int unsigned GROUP_CELLS = 256
) (
   input  logic [GROUP_CELLS-1:0]          col_hot,
   input  logic [DATA_W*GROUP_CELLS-1:0]   row_word,
   input  logic [DATA_W-1:0]               din,
   output logic [DATA_W-1:0]               rd_bits,
   output logic [DATA_W*GROUP_CELLS-1:0]   cell_mask,
   output logic [DATA_W*GROUP_CELLS-1:0]   cell_data
);
   for (genvar g = 0; g < DATA_W; g++) begin : g_group
      assign rd_bits[g] = |(row_word[g*GROUP_CELLS +: GROUP_CELLS] & col_hot);
      assign cell_mask[g*GROUP_CELLS +: GROUP_CELLS] = col_hot;
      assign cell_data[g*GROUP_CELLS +: GROUP_CELLS] = {GROUP_CELLS{din[g]}};
   end
endmodule

// File: rtl/sram_rc_array.sv
module sram_rc_array #(
   parameter int unsigned ROWS  = 256,
   parameter int unsigned CELLS = 256
) (
   input  logic               clk,
   input  logic               we,
   input  logic [ROWS-1:0]    row_hot,
   input  logic [CELLS-1:0]   cell_mask,
   input  logic [CELLS-1:0]   cell_data,
   output logic [CELLS-1:0]   row_word
);
   logic [ROWS-1:0][CELLS-1:0] gated;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [CELLS-1:0] cells_q;
      always_ff @(posedge clk) begin
         if (we && row_hot[r]) begin
            cells_q <= (cells_q & ~cell_mask) | (cell_data & cell_mask);
         end
      end
      assign gated[r] = cells_q & {CELLS{row_hot[r]}};
   end

   always_comb begin
      row_word = '0;
      for (int r = 0; r < ROWS; r++) begin
         row_word = row_word | gated[r];
      end
   end
endmodule

// File: rtl/sram_rc.sv
module sram_rc
   import sram_rc_pkg::*;
#(
   parameter int unsigned DATA_W   = 1,
   parameter int unsigned ROW_BITS = 8
) (
   input  logic                                   clk,
   input  logic [addr_bits(ROW_BITS, DATA_W)-1:0] addr,
   input  logic [DATA_W-1:0]                      din,
   input  logic                                   rw,
   input  logic                                   cs,
   output logic [DATA_W-1:0]                      dout
);
   localparam int unsigned ROWS   = 1 << ROW_BITS;
   localparam int unsigned CELLS  = row_cells(ROW_BITS);
   localparam int unsigned GC     = group_cells(ROW_BITS, DATA_W);
   localparam int unsigned COL_W  = col_bits(ROW_BITS, DATA_W);
   localparam int unsigned ADDR_W = addr_bits(ROW_BITS, DATA_W);

   if (!is_pow2(DATA_W) || DATA_W >= CELLS) begin : g_bad_dw
      $error("sram_rc: DATA_W must be a power of two below the row width");
   end
   if (ROW_BITS < 2 || COL_W < 1) begin : g_bad_geom
      $error("sram_rc: array geometry too small");
   end

   logic [ROW_BITS-1:0] row_code;
   logic [COL_W-1:0]    col_code;
   logic [ROWS-1:0]     row_hot;
   logic [GC-1:0]       col_hot;
   logic [CELLS-1:0]    row_word;
   logic [CELLS-1:0]    cell_mask;
   logic [CELLS-1:0]    cell_data;
   logic [DATA_W-1:0]   rd_bits;
   logic                we;
   logic                rd_en;

   assign row_code = addr[ROW_BITS-1:0];
   assign col_code = addr[ADDR_W-1:ROW_BITS];
   assign we       = cs && (rw == RW_WRITE);
   assign rd_en    = cs && (rw == RW_READ);

   sram_rc_dec #(.IN_W(ROW_BITS)) u_rowdec (
      .code (row_code),
      .hot  (row_hot)
   );

   sram_rc_dec #(.IN_W(COL_W)) u_coldec (
      .code (col_code),
      .hot  (col_hot)
   );

   sram_rc_colsel #(.DATA_W(DATA_W), .GROUP_CELLS(GC)) u_colsel (
      .col_hot   (col_hot),
      .row_word  (row_word),
      .din       (din),
      .rd_bits   (rd_bits),
      .cell_mask (cell_mask),
      .cell_data (cell_data)
   );

   sram_rc_array #(.ROWS(ROWS), .CELLS(CELLS)) u_array (
      .clk       (clk),
      .we        (we),
      .row_hot   (row_hot),
      .cell_mask (cell_mask),
      .cell_data (cell_data),
      .row_word  (row_word)
   );

   assign dout = rd_en ? rd_bits : '0;
endmodule

// File: rtl/sram_rc_chk.sv
module sram_rc_chk
   import sram_rc_pkg::*;
#(
   parameter int unsigned DATA_W   = 1,
   parameter int unsigned ROW_BITS = 8
) (
   input logic                                   clk,
   input logic [addr_bits(ROW_BITS, DATA_W)-1:0] addr,
   input logic [DATA_W-1:0]                      din,
   input logic                                   rw,
   input logic                                   cs,
   input logic [DATA_W-1:0]                      dout,
   input logic [(1 << ROW_BITS)-1:0]             row_hot,
   input logic [group_cells(ROW_BITS, DATA_W)-1:0] col_hot
);
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R6: idle output is zero
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!armed)
      !(cs && rw) |-> (dout == '0));

   // R4: a write is visible on an immediate read of the same address
   a_r4_write_readback: assert property (@(posedge clk) disable iff (!armed)
      (cs && !rw) |=> (!(cs && rw && addr == $past(addr)) || dout == $past(din)));

   // R5: back-to-back reads of one address agree
   a_r5_read_hold: assert property (@(posedge clk) disable iff (!armed)
      (cs && rw) |=> (!(cs && rw && addr == $past(addr)) || dout == $past(dout)));

   // R8: decoders give one active line
   a_r8_row_onehot: assert property (@(posedge clk) disable iff (!armed)
      cs |-> $onehot(row_hot));

   a_r8_col_onehot: assert property (@(posedge clk) disable iff (!armed)
      cs |-> $onehot(col_hot));
endmodule

bind sram_rc sram_rc_chk #(.DATA_W(DATA_W), .ROW_BITS(ROW_BITS)) u_chk (
   .clk     (clk),
   .addr    (addr),
   .din     (din),
   .rw      (rw),
   .cs      (cs),
   .dout    (dout),
   .row_hot (row_hot),
   .col_hot (col_hot)
);

// File: tb/sim_sram_rc.sv
`timescale 1ns/1ps
module sim_sram_rc;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   // u0: 64K x 1 (R2), u1: 16K x 4 (R3)
   logic        cs0 = 1'b0, rw0 = 1'b1, d0 = 1'b0;
   logic [15:0] a0 = '0;
   logic        dout0;
   logic        cs1 = 1'b0, rw1 = 1'b1;
   logic [13:0] a1 = '0;
   logic [3:0]  d1 = '0;
   logic [3:0]  dout1;

   sram_rc #(.DATA_W(1), .ROW_BITS(8)) u0 (
      .clk(clk), .addr(a0), .din(d0), .rw(rw0), .cs(cs0), .dout(dout0));
   sram_rc #(.DATA_W(4), .ROW_BITS(8)) u1 (
      .clk(clk), .addr(a1), .din(d1), .rw(rw1), .cs(cs1), .dout(dout1));

   // behavioural reference: word-indexed arrays plus written flags
   bit       m0 [65536];
   bit       v0 [65536];
   bit [3:0] m1 [16384];
   bit       v1 [16384];

   int checks = 0, fails = 0;
   bit running = 1'b0, finished = 1'b0;
   string ptag = "R6";

   always @(posedge clk) begin
      if (cs0 && !rw0) begin m0[a0] <= d0; v0[a0] <= 1'b1; end
      if (cs1 && !rw1) begin m1[a1] <= d1; v1[a1] <= 1'b1; end
   end

   task automatic chk(input bit ok, input string tag, input string who,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s t=%0t actual=%0h expected=%0h", tag, who, $time, act, exp);
      end
   endtask

   // compare every cycle, mid-cycle, against the model
   always @(negedge clk) begin
      if (running) begin
         if (cs0 && rw0) begin
            if (v0[a0]) chk(dout0 === m0[a0], {ptag, " R5"}, "u0(R2)", int'(dout0), int'(m0[a0]));
         end else begin
            chk(dout0 === 1'b0, "R6", "u0(R2)", int'(dout0), 0);
         end
         if (cs1 && rw1) begin
            if (v1[a1]) chk(dout1 === m1[a1], {ptag, " R5"}, "u1(R3)", int'(dout1), int'(m1[a1]));
         end else begin
            chk(dout1 === 4'h0, "R6", "u1(R3)", int'(dout1), 0);
         end
      end
   end

   task automatic op(input logic c0, input logic r0, input logic [15:0] x0, input logic y0,
                     input logic c1, input logic r1, input logic [13:0] x1, input logic [3:0] y1);
      @(posedge clk);
      #0.5;
      cs0 = c0; rw0 = r0; a0 = x0; d0 = y0;
      cs1 = c1; rw1 = r1; a1 = x1; d1 = y1;
   endtask

   function automatic logic [15:0] ad0(input int row, input int col);
      return {8'(col), 8'(row)};
   endfunction
   function automatic logic [13:0] ad1(input int row, input int col);
      return {6'(col), 8'(row)};
   endfunction
   function automatic logic p0(input logic [15:0] a);
      return ^(a * 16'h9E37 + 16'h1234);
   endfunction
   function automatic logic [3:0] p1(input logic [13:0] a);
      return 4'(a[3:0] ^ a[7:4] ^ {2'b00, a[13:12]} ^ a[11:8]) + 4'(a[8]);
   endfunction

   int rlist0 [6] = '{0, 1, 127, 128, 254, 255};
   int clist0 [6] = '{0, 1, 127, 128, 254, 255};
   int clist1 [6] = '{0, 1, 31, 32, 62, 63};

   initial begin
      repeat (3) @(posedge clk);
      running = 1'b1;
      // R6: idle state before any access
      ptag = "R6";
      repeat (4) op(0, 1, 16'h0, 0, 0, 1, 14'h0, 4'h0);

      // R1: corner rows x corner columns, all writes then all reads
      ptag = "R1";
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            op(1, 0, ad0(rlist0[i], clist0[j]), p0(ad0(rlist0[i], clist0[j])),
               1, 0, ad1(rlist0[i], clist1[j]), p1(ad1(rlist0[i], clist1[j])));
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            op(1, 1, ad0(rlist0[i], clist0[j]), 0, 1, 1, ad1(rlist0[i], clist1[j]), 4'h0);

      // R8: every row at both edge columns (row decoder)
      ptag = "R8";
      for (int r = 0; r < 256; r++) begin
         op(1, 0, ad0(r, 0),   ~p0(ad0(r, 0)),   1, 0, ad1(r, 0),  ~p1(ad1(r, 0)));
         op(1, 0, ad0(r, 255), ~p0(ad0(r, 255)), 1, 0, ad1(r, 63), ~p1(ad1(r, 63)));
      end
      for (int r = 0; r < 256; r++) begin
         op(1, 1, ad0(r, 0),   0, 1, 1, ad1(r, 0),  4'h0);
         op(1, 1, ad0(r, 255), 0, 1, 1, ad1(r, 63), 4'h0);
      end

      // R3/R2: every column of the edge rows (column mux/demux)
      ptag = "R3";
      for (int c = 0; c < 256; c++) begin
         op(1, 0, ad0(0, c),   p0(ad0(0, c) ^ 16'h5A5A),   1, 0, ad1(0, c % 64),   p1(ad1(0, c % 64)) ^ 4'(c));
         op(1, 0, ad0(255, c), p0(ad0(255, c) ^ 16'hA5A5), 1, 0, ad1(255, c % 64), p1(ad1(255, c % 64)) ^ 4'(c + 5));
      end
      for (int c = 0; c < 256; c++) begin
         op(1, 1, ad0(0, c),   0, 1, 1, ad1(0, c % 64),   4'h0);
         op(1, 1, ad0(255, c), 0, 1, 1, ad1(255, c % 64), 4'h0);
      end

      // R7: write cycles with cs low, inverted data, then read back unchanged
      ptag = "R7";
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            op(0, 0, ad0(rlist0[i], clist0[j]), ~m0[ad0(rlist0[i], clist0[j])],
               0, 0, ad1(rlist0[i], clist1[j]), ~m1[ad1(rlist0[i], clist1[j])]);
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            op(1, 1, ad0(rlist0[i], clist0[j]), 0, 1, 1, ad1(rlist0[i], clist1[j]), 4'h0);

      // R4: mixed traffic over a small address pool, incl. write-then-read
      ptag = "R4";
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] x0;
         logic [13:0] x1;
         x0 = 16'($urandom) & 16'hC1C3;
         x1 = 14'($urandom) & 14'h3083;
         op(($urandom % 8) != 0, $urandom % 2, x0, 1'($urandom),
            ($urandom % 8) != 0, $urandom % 2, x1, 4'($urandom));
      end

      op(0, 1, 16'h0, 0, 0, 1, 14'h0, 4'h0);
      @(negedge clk);
      #0.5;
      running = 1'b0;
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R4 actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule